// File: doc/BRIEF.md
# Next-PC Branch and Skip Resolver

This block picks the program counter that follows a control-flow instruction in a small 8-bit processor core. The decoder presents, for one instruction per valid cycle, the current word address, a 4-bit kind code, the zero, carry and sign status flags, the value of the single bit being tested, a 12-bit offset field, a 22-bit absolute target and a flag that says whether the instruction after this one occupies two words. One clock later the block returns the resolved next address and says whether control left the sequential path.

The block handles three families of instruction. Conditional branches test one flag for 1 or for 0 and use a signed 7-bit word displacement. Jumps are always taken: the relative form uses a signed 12-bit displacement, and the absolute form loads a target address directly. Skips step over the next instruction when the tested bit has the value they require, so they advance by two or three words depending on how long that next instruction is. Call and return stack handling are not part of the block, and neither is instruction decode.

Top module: `bsu_top`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, taken and next_pc are all 0.
- R2: out_valid equals in_valid from the previous cycle. In a cycle that follows one with in_valid low, next_pc and taken keep their earlier values, whatever the other inputs are doing.
- R3: Kind 1 is taken exactly when flag_z is 1, and kind 2 is taken exactly when flag_z is 0. The C and S flags have no effect on either kind.
- R4: Kind 3 (unsigned lower) is taken exactly when flag_c is 1, and kind 4 (same or higher) is taken exactly when flag_c is 0. Z and S have no effect on either kind.
- R5: Kind 5 (signed less) is taken exactly when flag_s is 1, and kind 6 (signed greater or equal) is taken exactly when flag_s is 0. Z and C have no effect on either kind.
- R6: A taken conditional branch (kinds 1 to 6) gives next_pc = pc + 1 + the sign extension of offset[6:0], computed modulo 2^16. Bits offset[11:7] are ignored.
- R7: Kind 7 (relative jump) is always taken. It gives next_pc = pc + 1 + the sign extension of offset[11:0], modulo 2^16, which reaches -2048 to +2047 words around pc + 1.
- R8: Kind 8 (absolute jump) is always taken. It gives next_pc = abs_target[15:0].
- R9: Kind 9 is taken when test_bit is 1, and kind 10 is taken when test_bit is 0. A taken skip gives pc + 3 when next_two_word is 1 and pc + 2 when it is 0.
- R10: A kind that is not taken, kind 0 (sequential) and the unused kinds 11 to 15 all give taken = 0 and next_pc = pc + 1, wrapping from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present this cycle |
| kind | input | 4 | Control-flow kind code (0 to 15) |
| pc | input | 16 | Word address of the current instruction |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag (N xor V) |
| test_bit | input | 1 | Value of the bit tested by a skip |
| offset | input | 12 | Displacement field; the low 7 bits are used by branches |
| abs_target | input | 22 | Absolute jump target |
| next_two_word | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | next_pc and taken are fresh |
| next_pc | output | 16 | Resolved next word address |
| taken | output | 1 | Control left the sequential path |

## Verification
The properties assume that the decoder drives kind, pc, the flags and the other fields only as values that go with in_valid, and that these fields are stable around the sampling edge. They do not constrain the fields while in_valid is low, so the hold check in R2 is valid for any values there. The bench changes every input only on the falling edge and holds it through the following rising edge. During the hold scenario it also drives misleading fields while in_valid is low, so the property sees those cycles exercised.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [3:0] {
        K_SEQ      = 4'd0,
        K_BR_ZSET  = 4'd1,
        K_BR_ZCLR  = 4'd2,
        K_BR_CSET  = 4'd3,
        K_BR_CCLR  = 4'd4,
        K_BR_SSET  = 4'd5,
        K_BR_SCLR  = 4'd6,
        K_JMP_REL  = 4'd7,
        K_JMP_ABS  = 4'd8,
        K_SKIP_ONE = 4'd9,
        K_SKIP_ZER = 4'd10
    } kind_e;

    localparam int unsigned KIND_W = 4;

    function automatic logic is_cond_branch(input logic [KIND_W-1:0] k);
        return (k >= K_BR_ZSET) && (k <= K_BR_SCLR);
    endfunction

endpackage

// File: rtl/bsu_cond_eval.sv
module bsu_cond_eval
    import bsu_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_s,
    input  logic              test_bit,
    output logic              take
);
    always_comb begin
        take = 1'b0;
        case (kind)
            K_BR_ZSET:  take = flag_z;
            K_BR_ZCLR:  take = ~flag_z;
            K_BR_CSET:  take = flag_c;
            K_BR_CCLR:  take = ~flag_c;
            K_BR_SSET:  take = flag_s;
            K_BR_SCLR:  take = ~flag_s;
            K_JMP_REL:  take = 1'b1;
            K_JMP_ABS:  take = 1'b1;
            K_SKIP_ONE: take = test_bit;
            K_SKIP_ZER: take = ~test_bit;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsu_target_calc.sv
module bsu_target_calc #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned BR_W  = 7,
    parameter int unsigned TGT_W = 22
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [TGT_W-1:0] abs_target,
    input  logic             next_two_word,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  br_pc,
    output logic [PC_W-1:0]  rel_pc,
    output logic [PC_W-1:0]  abs_pc,
    output logic [PC_W-1:0]  skip_pc
);
    localparam int unsigned BR_EXT  = PC_W - BR_W;
    localparam int unsigned OFF_EXT = PC_W - OFF_W;

    logic [PC_W-1:0] br_disp;
    logic [PC_W-1:0] rel_disp;
    logic [PC_W-1:0] skip_step;

    always_comb begin
        br_disp   = {{BR_EXT{offset[BR_W-1]}}, offset[BR_W-1:0]};
        rel_disp  = {{OFF_EXT{offset[OFF_W-1]}}, offset};
        skip_step = next_two_word ? PC_W'(3) : PC_W'(2);
        seq_pc    = pc + PC_W'(1);
        br_pc     = seq_pc + br_disp;
        rel_pc    = seq_pc + rel_disp;
        skip_pc   = pc + skip_step;
    end

    generate
        if (TGT_W > PC_W) begin : g_trunc
            logic unused_tgt_hi;
            assign unused_tgt_hi = ^abs_target[TGT_W-1:PC_W];
            assign abs_pc = abs_target[PC_W-1:0];
        end else begin : g_extend
            assign abs_pc = PC_W'(abs_target);
        end
    endgenerate
endmodule

// File: rtl/bsu_top.sv
module bsu_top
    import bsu_pkg::*;
#(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned BR_W  = 7,
    parameter int unsigned TGT_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        kind,
    input  logic [PC_W-1:0]   pc,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_s,
    input  logic              test_bit,
    input  logic [OFF_W-1:0]  offset,
    input  logic [TGT_W-1:0]  abs_target,
    input  logic              next_two_word,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken
);
    typedef struct packed {
        logic            vld;
        logic            tkn;
        logic [PC_W-1:0] npc;
    } res_t;

    res_t res_d, res_q;

    logic            take;
    logic [PC_W-1:0] seq_pc, br_pc, rel_pc, abs_pc, skip_pc;

    bsu_cond_eval u_cond (
        .kind     (kind),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .flag_s   (flag_s),
        .test_bit (test_bit),
        .take     (take)
    );

    bsu_target_calc #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W),
        .BR_W  (BR_W),
        .TGT_W (TGT_W)
    ) u_tgt (
        .pc            (pc),
        .offset        (offset),
        .abs_target    (abs_target),
        .next_two_word (next_two_word),
        .seq_pc        (seq_pc),
        .br_pc         (br_pc),
        .rel_pc        (rel_pc),
        .abs_pc        (abs_pc),
        .skip_pc       (skip_pc)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.tkn = take;
            if (!take) begin
                res_d.npc = seq_pc;
            end else if (is_cond_branch(kind)) begin
                res_d.npc = br_pc;
            end else begin
                case (kind)
                    K_JMP_REL:  res_d.npc = rel_pc;
                    K_JMP_ABS:  res_d.npc = abs_pc;
                    K_SKIP_ONE,
                    K_SKIP_ZER: res_d.npc = skip_pc;
                    default:    res_d.npc = seq_pc;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.tkn;
    assign next_pc   = res_q.npc;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned TGT_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       kind,
    input logic [PC_W-1:0]  pc,
    input logic             flag_z,
    input logic             test_bit,
    input logic [OFF_W-1:0] offset,
    input logic [TGT_W-1:0] abs_target,
    input logic             next_two_word,
    input logic             out_valid,
    input logic [PC_W-1:0]  next_pc,
    input logic             taken
);
    logic [PC_W-1:0] rel_exp;
    logic [PC_W-1:0] skip_exp;
    logic [PC_W-1:0] seq_exp;

    assign seq_exp  = pc + PC_W'(1);
    assign rel_exp  = seq_exp + PC_W'({{(PC_W-OFF_W){offset[OFF_W-1]}}, offset});
    assign skip_exp = pc + (next_two_word ? PC_W'(3) : PC_W'(2));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !taken && (next_pc == '0));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(next_pc) && $stable(taken));

    p_zset_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && kind == 4'd1 |=> taken == $past(flag_z));

    p_rel_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && kind == 4'd7 |=> taken && next_pc == $past(rel_exp));

    p_abs_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && kind == 4'd8 |=> taken && next_pc == $past(abs_target[PC_W-1:0]));

    p_skip_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && kind == 4'd9 && test_bit |=> taken && next_pc == $past(skip_exp));

    p_seq_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (kind == 4'd0 || kind > 4'd10) |=> !taken && next_pc == $past(seq_exp));
endmodule

bind bsu_top bsu_checker #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W),
    .TGT_W (TGT_W)
) u_bsu_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .kind          (kind),
    .pc            (pc),
    .flag_z        (flag_z),
    .test_bit      (test_bit),
    .offset        (offset),
    .abs_target    (abs_target),
    .next_two_word (next_two_word),
    .out_valid     (out_valid),
    .next_pc       (next_pc),
    .taken         (taken)
);

// File: tb/bsu_top_bench.sv
`timescale 1ns/1ps
module bsu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  kind = '0;
    logic [15:0] pc = '0;
    logic        flag_z = 1'b0, flag_c = 1'b0, flag_s = 1'b0, test_bit = 1'b0;
    logic [11:0] offset = '0;
    logic [21:0] abs_target = '0;
    logic        next_two_word = 1'b0;
    logic        out_valid;
    logic [15:0] next_pc;
    logic        taken;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bsu_top u_bsu_top (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .kind (kind), .pc (pc),
        .flag_z (flag_z), .flag_c (flag_c), .flag_s (flag_s), .test_bit (test_bit),
        .offset (offset), .abs_target (abs_target), .next_two_word (next_two_word),
        .out_valid (out_valid), .next_pc (next_pc), .taken (taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, let one rising edge register it, sample on the next falling edge.
    task automatic issue(input logic [3:0] k, input logic [15:0] p, input logic z, input logic c,
                         input logic s, input logic tb, input logic [11:0] off,
                         input logic [21:0] tgt, input logic two,
                         input logic [15:0] exp_pc, input logic exp_tkn, input string req);
        @(negedge clk);
        in_valid = 1'b1; kind = k; pc = p; flag_z = z; flag_c = c; flag_s = s;
        test_bit = tb; offset = off; abs_target = tgt; next_two_word = two;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " taken"}, 32'(taken), 32'(exp_tkn));
        check({req, " next_pc"}, 32'(next_pc), 32'(exp_pc));
    endtask

    task automatic t_reset_r1();
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 taken", 32'(taken), 32'd0);
        check("R1 next_pc", 32'(next_pc), 32'd0);
    endtask

    task automatic t_zero_flag_r3();
        issue(4'd1, 16'h1000, 1, 0, 0, 0, 12'h005, '0, 0, 16'h1006, 1, "R3 eq z1");
        issue(4'd1, 16'h1000, 0, 1, 1, 1, 12'h005, '0, 0, 16'h1001, 0, "R3 eq z0");
        issue(4'd2, 16'h1000, 0, 1, 1, 0, 12'h005, '0, 0, 16'h1006, 1, "R3 ne z0");
        issue(4'd2, 16'h1000, 1, 0, 0, 0, 12'h005, '0, 0, 16'h1001, 0, "R3 ne z1");
    endtask

    task automatic t_carry_flag_r4();
        issue(4'd3, 16'h0400, 0, 1, 0, 0, 12'h010, '0, 0, 16'h0411, 1, "R4 lo c1");
        issue(4'd3, 16'h0400, 1, 0, 1, 0, 12'h010, '0, 0, 16'h0401, 0, "R4 lo c0");
        issue(4'd4, 16'h0400, 1, 0, 1, 0, 12'h010, '0, 0, 16'h0411, 1, "R4 sh c0");
        issue(4'd4, 16'h0400, 0, 1, 0, 0, 12'h010, '0, 0, 16'h0401, 0, "R4 sh c1");
    endtask

    task automatic t_sign_flag_r5();
        issue(4'd5, 16'h0800, 0, 0, 1, 0, 12'h001, '0, 0, 16'h0802, 1, "R5 lt s1");
        issue(4'd5, 16'h0800, 1, 1, 0, 0, 12'h001, '0, 0, 16'h0801, 0, "R5 lt s0");
        issue(4'd6, 16'h0800, 1, 1, 0, 0, 12'h001, '0, 0, 16'h0802, 1, "R5 ge s0");
        issue(4'd6, 16'h0800, 0, 0, 1, 0, 12'h001, '0, 0, 16'h0801, 0, "R5 ge s1");
    endtask

    task automatic t_branch_disp_r6();
        // offset[6:0] = 0x40 is -64
        issue(4'd1, 16'h2000, 1, 0, 0, 0, 12'hFC0, '0, 0, 16'h1FC1, 1, "R6 back -64");
        // offset[6:0] = 0x3F is +63, upper field bits set must be ignored
        issue(4'd2, 16'h2000, 0, 0, 0, 0, 12'hFBF, '0, 0, 16'h2040, 1, "R6 fwd +63");
        issue(4'd1, 16'h0100, 1, 0, 0, 0, 12'hF85, '0, 0, 16'h0106, 1, "R6 high bits ignored");
        issue(4'd1, 16'h0010, 1, 0, 0, 0, 12'h07F, '0, 0, 16'h0010, 1, "R6 minus one");
    endtask

    task automatic t_rel_jump_r7();
        issue(4'd7, 16'h0100, 0, 0, 0, 0, 12'h7FF, '0, 0, 16'h0900, 1, "R7 max fwd");
        issue(4'd7, 16'h0100, 0, 0, 0, 0, 12'h800, '0, 0, 16'hF901, 1, "R7 max back wrap");
        issue(4'd7, 16'hFFFF, 1, 1, 1, 1, 12'h003, '0, 1, 16'h0003, 1, "R7 wrap fwd");
    endtask

    task automatic t_abs_jump_r8();
        issue(4'd8, 16'h1234, 0, 0, 0, 0, 12'h000, 22'h3ABCDE, 0, 16'hBCDE, 1, "R8 abs");
        issue(4'd8, 16'h1234, 1, 1, 1, 1, 12'hFFF, 22'h000000, 1, 16'h0000, 1, "R8 abs zero");
    endtask

    task automatic t_skip_r9();
        issue(4'd9,  16'h0200, 0, 0, 0, 1, '0, '0, 0, 16'h0202, 1, "R9 set one-word");
        issue(4'd9,  16'h0200, 0, 0, 0, 1, '0, '0, 1, 16'h0203, 1, "R9 set two-word");
        issue(4'd9,  16'h0200, 1, 1, 1, 0, '0, '0, 1, 16'h0201, 0, "R9 set fails");
        issue(4'd10, 16'h0200, 1, 1, 1, 0, '0, '0, 1, 16'h0203, 1, "R9 clr two-word");
        issue(4'd10, 16'h0200, 0, 0, 0, 0, '0, '0, 0, 16'h0202, 1, "R9 clr one-word");
        issue(4'd10, 16'h0200, 0, 0, 0, 1, '0, '0, 0, 16'h0201, 0, "R9 clr fails");
    endtask

    task automatic t_sequential_r10();
        issue(4'd0, 16'hFFFF, 1, 1, 1, 1, 12'h7FF, 22'h3FFFFF, 1, 16'h0000, 0, "R10 seq wrap");
        issue(4'd0, 16'h0042, 0, 0, 0, 0, '0, '0, 0, 16'h0043, 0, "R10 seq");
        for (int k = 11; k < 16; k++) begin
            issue(4'(k), 16'h0042, 1, 1, 1, 1, 12'h123, 22'h012345, 1, 16'h0043, 0, "R10 unused kind");
        end
    endtask

    task automatic t_hold_r2();
        issue(4'd8, 16'h0000, 0, 0, 0, 0, '0, 22'h00ABCD, 0, 16'hABCD, 1, "R2 setup");
        @(negedge clk);
        in_valid = 1'b0; kind = 4'd7; pc = 16'h5555; offset = 12'h123; flag_z = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 idle valid", 32'(out_valid), 32'd0);
            check("R2 idle next_pc", 32'(next_pc), 32'h0000ABCD);
            check("R2 idle taken", 32'(taken), 32'd1);
            kind = 4'(i);
        end
        issue(4'd0, 16'h0010, 0, 0, 0, 0, '0, '0, 0, 16'h0011, 0, "R2 resume");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_zero_flag_r3();
        t_carry_flag_r4();
        t_sign_flag_r5();
        t_branch_disp_r6();
        t_rel_jump_r7();
        t_abs_jump_r8();
        t_skip_r9();
        t_sequential_r10();
        t_hold_r2();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule